// File: doc/BRIEF.md
# Multi-Channel PMIC Command Front End

This block gives several software agents their own independent path for issuing register reads and writes to a power-management device. Each agent owns one channel, which is a small set of memory-mapped registers on a simple write/read bus. To launch a transaction, software writes a single 32-bit command word into the channel's access register. That word packs the command type, the write flag, the slave id, the byte count and the register address. Every channel has a four-state handshake machine, and software can read its state at any time.

All channels share one downstream request/acknowledge master port, which feeds a serial bus master. A round-robin arbiter hands the port to one waiting channel at a time. It keeps the grant until the port acknowledges. A read stays parked once its data arrives, and the channel is released only when software writes one to the valid-clear register. A write returns to idle on the acknowledge, with no further software step. A command launched on a busy channel is dropped, and a sticky error bit records the attempt.

Top module: `pmic_cmd_front`

## Requirements
- R1: After reset, every channel reads idle status 0x0, write data 0 and read data 0.
- R2: Channel n's registers sit at 0xC00 + 0x40·n. The offsets are: access 0x00, write data 0x04, read data 0x14, valid-clear 0x24, status 0x28. The status word carries the state in bits [3:1] and the error flag in bit 0, and all other bits read zero. State codes are: 0 idle, 1 waiting for grant, 2 on the master port, 6 waiting for valid-clear.
- R3: Writing the access register of an idle channel moves it to state 1. On the master port the word appears with type = bits [31:30], write = bit 29, slave id = bits [27:24], byte count = bits [23:16] and address = bits [15:0].
- R4: While the master request is high and not yet acknowledged, the request and all its fields stay stable. The cycle after an acknowledge, the request is low.
- R5: A read's acknowledge stores the returned word into read data and moves the channel to state 6. Only the low (count[1:0]+1) bytes are kept, little-endian, and the upper bytes are cleared.
- R6: A channel in state 6 stays there until a valid-clear write with bit 0 set. That write returns it to idle and clears the error flag.
- R7: A write command completes to idle on its acknowledge. It has no valid-clear step and leaves read data untouched. The master port's write data carries only the low (count[1:0]+1) bytes of the write-data register.
- R8: A write to the access register of a non-idle channel launches nothing and does not change the channel's state or command. It sets status bit 0.
- R9: A write to the write-data register of a non-idle channel is ignored.
- R10: The arbiter grants waiting channels in round-robin order. The search starts from the channel after the one served last.
- R11: At most one channel is on the master port at any time.
- R12: Reads of unmapped addresses, of the access register and of the valid-clear register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| mst_req | output | 1 | Master port request |
| mst_kind | output | 2 | Command type |
| mst_wr | output | 1 | 1 = write transaction |
| mst_sid | output | 4 | Slave id |
| mst_bcnt | output | 8 | Byte count minus one |
| mst_raddr | output | 16 | Device register address |
| mst_wdata | output | 32 | Write bytes, unused lanes zero |
| mst_ack | input | 1 | Master port acknowledge |
| mst_rdata | input | 32 | Read data, valid with mst_ack |

## Verification
A channel stuck in a wrong state shows up in its status word on the very next bus read. Such a channel either never reaches state 6 or leaves it without a valid-clear, so a poll of the status register exposes it within a few cycles of the acknowledge. A fault in the arbiter appears as a wrong slave id in the order of requests at the master port. A fault in the byte lanes appears as stray upper bytes in read data or in the master's write data. The bench therefore sweeps every channel against every byte count and every command type. It adds launches on busy channels and rounds where several channels are pending at once, and it computes every expected word and every service order arithmetically.

// File: rtl/pmic_cmd_pkg.sv
package pmic_cmd_pkg;

    localparam int unsigned DATA_W = 32;

    // register offsets inside one channel slot
    localparam logic [5:0] OFS_ACC  = 6'h00;
    localparam logic [5:0] OFS_WDAT = 6'h04;
    localparam logic [5:0] OFS_RDAT = 6'h14;
    localparam logic [5:0] OFS_VCLR = 6'h24;
    localparam logic [5:0] OFS_STAT = 6'h28;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_GNT  = 3'd1,
        ST_ON_PORT   = 3'd2,
        ST_WAIT_VCLR = 3'd6
    } chan_st_e;

    typedef struct packed {
        logic [1:0]  kind;
        logic        wr;
        logic [3:0]  sid;
        logic [7:0]  bcnt;
        logic [15:0] raddr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.kind  = w[31:30];
        c.wr    = w[29];
        c.sid   = w[27:24];
        c.bcnt  = w[23:16];
        c.raddr = w[15:0];
        return c;
    endfunction

    // keeps bytes 0..n of a little-endian data word
    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] n);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < DATA_W / 8; b++) begin
            m[b*8 +: 8] = (b <= int'(n)) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction

endpackage

// File: rtl/pmic_chan.sv
module pmic_chan
    import pmic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              wdat_wr,
    input  logic              vclr_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              grant,
    input  logic              done,
    input  logic [DATA_W-1:0] mst_rdata,
    output logic              pending,
    output logic              on_port,
    output cmd_t              cmd_o,
    output logic [DATA_W-1:0] wdat_o,
    output logic [DATA_W-1:0] rdat_o,
    output logic [DATA_W-1:0] stat_o
);

    typedef struct packed {
        chan_st_e          st;
        logic              err;
        cmd_t              cmd;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
    } ch_regs_t;

    ch_regs_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        unique case (ch_q.st)
            ST_IDLE: begin
                if (acc_wr) begin
                    ch_d.cmd = decode_cmd(bus_wdata);
                    ch_d.st  = ST_WAIT_GNT;
                end else if (wdat_wr) begin
                    ch_d.wdat = bus_wdata;
                end
            end
            ST_WAIT_GNT: begin
                if (grant) ch_d.st = ST_ON_PORT;
            end
            ST_ON_PORT: begin
                if (done) begin
                    if (ch_q.cmd.wr) begin
                        ch_d.st = ST_IDLE;
                    end else begin
                        ch_d.rdat = mst_rdata & lane_mask(ch_q.cmd.bcnt[1:0]);
                        ch_d.st   = ST_WAIT_VCLR;
                    end
                end
            end
            ST_WAIT_VCLR: ;
            default: ch_d.st = ST_IDLE;
        endcase
        if (acc_wr && ch_q.st != ST_IDLE) ch_d.err = 1'b1;
        if (vclr_wr && bus_wdata[0]) begin
            ch_d.err = 1'b0;
            if (ch_q.st == ST_WAIT_VCLR) ch_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign pending = (ch_q.st == ST_WAIT_GNT);
    assign on_port = (ch_q.st == ST_ON_PORT);
    assign cmd_o   = ch_q.cmd;
    assign wdat_o  = ch_q.wdat;
    assign rdat_o  = ch_q.rdat;
    assign stat_o  = {{(DATA_W-4){1'b0}}, ch_q.st, ch_q.err};

    // R8: a launch on a busy channel leaves the error flag set
    p_busy_launch_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr && ch_q.st != ST_IDLE |=> ch_q.err);

    // R6: a parked read only leaves on valid-clear
    p_read_parks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q.st == ST_WAIT_VCLR && !(vclr_wr && bus_wdata[0]) |=> ch_q.st == ST_WAIT_VCLR);

    // R7: a finished write goes straight to idle
    p_write_skips_vclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && ch_q.st == ST_ON_PORT && ch_q.cmd.wr |=> ch_q.st == ST_IDLE);

    // R9: write data frozen while busy
    p_wdat_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q.st != ST_IDLE |=> $stable(ch_q.wdat));

    // R5: parked read data has clean upper lanes
    p_rdat_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q.st == ST_WAIT_VCLR |-> (ch_q.rdat & ~lane_mask(ch_q.cmd.bcnt[1:0])) == '0);

endmodule

// File: rtl/pmic_rr_arb.sv
module pmic_rr_arb #(
    parameter int NCH   = 4,
    parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   pend,
    input  logic             ack,
    output logic             busy,
    output logic [IDX_W-1:0] owner,
    output logic             new_gnt,
    output logic [IDX_W-1:0] new_idx
);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
    } arb_regs_t;

    arb_regs_t arb_d, arb_q;
    logic      found;

    always_comb begin
        found   = 1'b0;
        new_idx = '0;
        for (int k = 1; k <= NCH; k++) begin
            int c;
            c = int'(arb_q.last) + k;
            if (c >= NCH) c = c - NCH;
            if (!found && pend[c]) begin
                found   = 1'b1;
                new_idx = IDX_W'(c);
            end
        end

        arb_d   = arb_q;
        new_gnt = 1'b0;
        if (arb_q.busy) begin
            if (ack) begin
                arb_d.busy = 1'b0;
                arb_d.last = arb_q.idx;
            end
        end else if (found) begin
            arb_d.busy = 1'b1;
            arb_d.idx  = new_idx;
            new_gnt    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q.busy <= 1'b0;
            arb_q.idx  <= '0;
            arb_q.last <= IDX_W'(NCH - 1);
        end else begin
            arb_q <= arb_d;
        end
    end

    assign busy  = arb_q.busy;
    assign owner = arb_q.idx;

    // R11: grant is held until acknowledge
    p_grant_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        arb_q.busy && !ack |=> arb_q.busy && $stable(arb_q.idx));

    // R10: a new grant always lands on a waiting channel
    p_grant_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        new_gnt |-> pend[new_idx]);

endmodule

// File: rtl/pmic_cmd_front.sv
module pmic_cmd_front
    import pmic_cmd_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int AW        = 12,
    parameter int BASE      = 'hC00,
    parameter int STRIDE_LG = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          mst_req,
    output logic [1:0]    mst_kind,
    output logic          mst_wr,
    output logic [3:0]    mst_sid,
    output logic [7:0]    mst_bcnt,
    output logic [15:0]   mst_raddr,
    output logic [31:0]   mst_wdata,
    input  logic          mst_ack,
    input  logic [31:0]   mst_rdata
);

    localparam int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int SLOT_W = AW - STRIDE_LG;
    localparam logic [AW-1:0]     BASE_V    = AW'(BASE);
    localparam logic [SLOT_W-1:0] BASE_SLOT = BASE_V[AW-1:STRIDE_LG];

    logic [SLOT_W-1:0]    slot;
    logic [STRIDE_LG-1:0] ofs;
    logic [NCH-1:0]       hit, pend, onport;
    logic [NCH-1:0]       acc_wr, wdat_wr, vclr_wr, grant, done;
    cmd_t                 cmd_a  [NCH];
    logic [31:0]          wdat_a [NCH];
    logic [31:0]          rdat_a [NCH];
    logic [31:0]          stat_a [NCH];
    logic                 busy, new_gnt;
    logic [IDX_W-1:0]     owner, new_idx;
    cmd_t                 sel_cmd;

    assign slot = bus_addr[AW-1:STRIDE_LG];
    assign ofs  = bus_addr[STRIDE_LG-1:0];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign hit[i]     = (slot == BASE_SLOT + SLOT_W'(i));
        assign acc_wr[i]  = bus_we && hit[i] && ofs == STRIDE_LG'(OFS_ACC);
        assign wdat_wr[i] = bus_we && hit[i] && ofs == STRIDE_LG'(OFS_WDAT);
        assign vclr_wr[i] = bus_we && hit[i] && ofs == STRIDE_LG'(OFS_VCLR);
        assign grant[i]   = new_gnt && new_idx == IDX_W'(i);
        assign done[i]    = mst_ack && busy && owner == IDX_W'(i);

        pmic_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_wr    (acc_wr[i]),
            .wdat_wr   (wdat_wr[i]),
            .vclr_wr   (vclr_wr[i]),
            .bus_wdata (bus_wdata),
            .grant     (grant[i]),
            .done      (done[i]),
            .mst_rdata (mst_rdata),
            .pending   (pend[i]),
            .on_port   (onport[i]),
            .cmd_o     (cmd_a[i]),
            .wdat_o    (wdat_a[i]),
            .rdat_o    (rdat_a[i]),
            .stat_o    (stat_a[i])
        );
    end

    pmic_rr_arb #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .ack     (mst_ack),
        .busy    (busy),
        .owner   (owner),
        .new_gnt (new_gnt),
        .new_idx (new_idx)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit[i]) begin
                if (ofs == STRIDE_LG'(OFS_WDAT)) bus_rdata = wdat_a[i];
                if (ofs == STRIDE_LG'(OFS_RDAT)) bus_rdata = rdat_a[i];
                if (ofs == STRIDE_LG'(OFS_STAT)) bus_rdata = stat_a[i];
            end
        end
    end

    assign sel_cmd   = cmd_a[owner];
    assign mst_req   = busy;
    assign mst_kind  = sel_cmd.kind;
    assign mst_wr    = sel_cmd.wr;
    assign mst_sid   = sel_cmd.sid;
    assign mst_bcnt  = sel_cmd.bcnt;
    assign mst_raddr = sel_cmd.raddr;
    assign mst_wdata = wdat_a[owner] & lane_mask(sel_cmd.bcnt[1:0]);

    // R11: never two channels on the master port
    p_single_on_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(onport));

    // R4: request and fields stay put until acknowledged
    p_req_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mst_req && !mst_ack |=> mst_req &&
        $stable({mst_kind, mst_wr, mst_sid, mst_bcnt, mst_raddr, mst_wdata}));

    // R4: request drops after acknowledge
    p_req_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mst_req && mst_ack |=> !mst_req);

endmodule

// File: tb/pmic_cmd_front_tb.sv
`timescale 1ns/1ps
module pmic_cmd_front_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mst_req, mst_wr;
    logic [1:0]  mst_kind;
    logic [3:0]  mst_sid;
    logic [7:0]  mst_bcnt;
    logic [15:0] mst_raddr;
    logic [31:0] mst_wdata;
    logic        mst_ack = 1'b0;
    logic [31:0] mst_rdata = '0;

    always #4 clk = ~clk;

    pmic_cmd_front u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mst_req(mst_req),
        .mst_kind(mst_kind), .mst_wr(mst_wr), .mst_sid(mst_sid),
        .mst_bcnt(mst_bcnt), .mst_raddr(mst_raddr), .mst_wdata(mst_wdata),
        .mst_ack(mst_ack), .mst_rdata(mst_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int lat = 0;
    int wcnt = 0;
    int nlog = 0;
    logic [30:0] log_cmd [256];
    logic [31:0] log_wd  [256];

    function automatic logic [31:0] resp(input logic [15:0] a, input logic [3:0] s);
        return {a[7:0] ^ 8'hA5, 4'h3, s, a};
    endfunction

    function automatic logic [31:0] lanes(input int bc);
        return (bc == 3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (bc + 1))) - 32'h1);
    endfunction

    function automatic logic [11:0] ra(input int ch, input int ofs);
        return 12'(32'hC00 + ch * 64 + ofs);
    endfunction

    // master port model
    always @(posedge clk) begin
        if (!rst_n) begin
            mst_ack <= 1'b0;
            wcnt = 0;
        end else if (mst_req && !mst_ack) begin
            if (wcnt >= lat) begin
                mst_ack   <= 1'b1;
                mst_rdata <= resp(mst_raddr, mst_sid);
                log_cmd[nlog & 255] = {mst_kind, mst_wr, mst_sid, mst_bcnt, mst_raddr};
                log_wd[nlog & 255]  = mst_wdata;
                nlog = nlog + 1;
                wcnt = 0;
            end else begin
                wcnt = wcnt + 1;
            end
        end else begin
            mst_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_state(input int ch, input int st, input string tag);
        logic [31:0] s;
        bit ok = 0;
        for (int t = 0; t < 400; t++) begin
            bus_read(ra(ch, 'h28), s);
            if (int'(s[3:1]) == st) begin ok = 1; break; end
            @(negedge clk);
        end
        if (!ok) chk({tag, " state timeout"}, s, 32'(st << 1));
    endtask

    logic [31:0] rv;
    logic [31:0] prev_rd [4];

    initial begin
        #1200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int ch = 0; ch < 4; ch++) begin
            bus_read(ra(ch, 'h28), rv); chk("R1 status", rv, 0);
            bus_read(ra(ch, 'h04), rv); chk("R1 wdata", rv, 0);
            bus_read(ra(ch, 'h14), rv); chk("R1 rdata", rv, 0);
        end

        // R3 R5 R6 read sweep over channels, counts, types
        for (int ch = 0; ch < 4; ch++) begin
            for (int bc = 0; bc < 4; bc++) begin
                logic [3:0]  sid;
                logic [7:0]  cnt;
                logic [15:0] adr;
                logic [31:0] w;
                int n0;
                sid = 4'(ch * 3 + 1);
                cnt = 8'(bc | (ch << 2));
                adr = 16'(16'h1234 + ch * 16 + bc * 257);
                w   = {2'(bc), 1'b0, 1'b0, sid, cnt, adr};
                lat = bc + ch;
                n0  = nlog;
                bus_write(ra(ch, 'h00), w);
                bus_read(ra(ch, 'h28), rv); chk("R3 launch status", rv, 32'h2);
                wait_state(ch, 6, "R5");
                bus_read(ra(ch, 'h28), rv); chk("R5 parked status", rv, 32'hC);
                bus_read(ra(ch, 'h14), rv); chk("R5 rdata lanes", rv, resp(adr, sid) & lanes(bc));
                prev_rd[ch] = resp(adr, sid) & lanes(bc);
                chk("R3 fields", 32'(log_cmd[n0 & 255]), 32'({2'(bc), 1'b0, sid, cnt, adr}));
                chk("R11 one transaction", 32'(nlog - n0), 1);
                repeat (3) @(negedge clk);
                bus_read(ra(ch, 'h28), rv); chk("R6 still parked", rv, 32'hC);
                bus_write(ra(ch, 'h24), 32'h1);
                bus_read(ra(ch, 'h28), rv); chk("R6 valid-clear", rv, 32'h0);
            end
        end

        // R7 write sweep
        for (int ch = 0; ch < 4; ch++) begin
            for (int bc = 0; bc < 4; bc++) begin
                logic [31:0] wd;
                logic [15:0] adr;
                int n0;
                wd  = 32'hC3A5_5A3C ^ 32'((ch * 4 + bc) * 32'h0101_0101);
                adr = 16'(16'h0F00 + ch * 4 + bc);
                lat = 3 - bc;
                n0  = nlog;
                bus_write(ra(ch, 'h04), wd);
                bus_read(ra(ch, 'h04), rv); chk("R7 wdata readback", rv, wd);
                bus_write(ra(ch, 'h00), {2'd1, 1'b1, 1'b0, 4'(ch + 8), 8'(bc), adr});
                wait_state(ch, 0, "R7");
                bus_read(ra(ch, 'h28), rv); chk("R7 idle no vclr", rv, 32'h0);
                chk("R7 master wdata", log_wd[n0 & 255], wd & lanes(bc));
                chk("R7 fields", 32'(log_cmd[n0 & 255]), 32'({2'd1, 1'b1, 4'(ch + 8), 8'(bc), adr}));
                bus_read(ra(ch, 'h14), rv); chk("R7 rdata untouched", rv, prev_rd[ch]);
            end
        end

        // R8 R9 launch on a busy channel
        begin
            int n0;
            lat = 20;
            n0  = nlog;
            bus_write(ra(1, 'h04), 32'h1111_2222);
            bus_write(ra(1, 'h00), {2'd2, 1'b0, 1'b0, 4'd5, 8'd3, 16'h00AA});
            bus_write(ra(1, 'h00), {2'd3, 1'b1, 1'b0, 4'd9, 8'd0, 16'h0055});
            bus_read(ra(1, 'h28), rv); chk("R8 error flag on busy", rv, 32'h5);
            bus_write(ra(1, 'h04), 32'hDEAD_BEEF);
            bus_read(ra(1, 'h04), rv); chk("R9 wdata ignored", rv, 32'h1111_2222);
            wait_state(1, 6, "R8");
            bus_read(ra(1, 'h28), rv); chk("R8 error kept", rv, 32'hD);
            bus_read(ra(1, 'h14), rv); chk("R8 first cmd served", rv, resp(16'h00AA, 4'd5));
            repeat (30) @(negedge clk);
            chk("R8 no extra transaction", 32'(nlog - n0), 1);
            bus_write(ra(1, 'h00), {2'd1, 1'b0, 1'b0, 4'd7, 8'd0, 16'h0077});
            bus_read(ra(1, 'h28), rv); chk("R8 launch in state 6", rv, 32'hD);
            bus_read(ra(1, 'h14), rv); chk("R8 rdata kept", rv, resp(16'h00AA, 4'd5));
            bus_write(ra(1, 'h24), 32'h1);
            bus_read(ra(1, 'h28), rv); chk("R6 clear error", rv, 32'h0);
            chk("R8 still one transaction", 32'(nlog - n0), 1);
        end

        // R10 R11 round robin rounds
        for (int r = 0; r < 4; r++) begin
            int order [4];
            int exp_ord [4];
            bit pend [4];
            int last, n0;
            order[0] = r;
            for (int k = 1; k < 4; k++) order[k] = (r + k * (r % 2 == 0 ? 1 : 3)) % 4;
            lat = 12;
            n0  = nlog;
            for (int k = 0; k < 4; k++)
                bus_write(ra(order[k], 'h00), {2'd1, 1'b0, 1'b0, 4'(order[k] * 3 + 1), 8'd3, 16'(16'h4000 + k)});
            exp_ord[0] = r;
            for (int c = 0; c < 4; c++) pend[c] = (c != r);
            last = r;
            for (int k = 1; k < 4; k++) begin
                for (int j = 1; j <= 4; j++) begin
                    int c;
                    c = (last + j) % 4;
                    if (pend[c]) begin exp_ord[k] = c; pend[c] = 0; last = c; break; end
                end
            end
            for (int c = 0; c < 4; c++) wait_state(c, 6, "R10");
            chk("R11 four transactions", 32'(nlog - n0), 4);
            for (int k = 0; k < 4; k++)
                chk("R10 service order", 32'(log_cmd[(n0 + k) & 255][27:24]), 32'(exp_ord[k] * 3 + 1));
            for (int c = 0; c < 4; c++) bus_write(ra(c, 'h24), 32'h1);
        end

        // R12 unmapped and write-only reads
        bus_read(12'h000, rv);     chk("R12 unmapped low", rv, 0);
        bus_read(ra(0, 'h30), rv); chk("R12 hole in slot", rv, 0);
        bus_read(ra(2, 'h00), rv); chk("R12 access reads zero", rv, 0);
        bus_read(ra(3, 'h24), rv); chk("R12 vclr reads zero", rv, 0);
        bus_read(ra(4, 'h28), rv); chk("R12 slot beyond range", rv, 0);
        bus_read(ra(2, 'h28), rv); chk("R2 status layout idle", rv, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule